// File: doc/BRIEF.md
# Complex Twiddle-Factor Multiplier for an 8x8 Split 64-Point Transform

This block rotates one complex sample by a power of the 64th root of unity. A 64-point transform can be built as two passes of 8-point transforms. Between the row pass and the column pass, every sample must be multiplied by a factor W^e, where e is a 6-bit exponent. The block accepts a sample with a valid strobe, the exponent and a direction bit. Two clock cycles later it returns the rotated sample with its own valid strobe. The direction bit selects the forward transform or, in inverse mode, the complex conjugate of the factor.

The real and imaginary parts are 16-bit signed integers. No coefficient store is used. The exponent is split into a quarter-turn count and a residue from 0 to 15. The quarter turn is applied exactly, by swapping and negating the two parts. The residue angle is applied by fixed constant-multiplier networks, each built from canonical signed-digit shift-and-add terms. All products and sums are carried at 32 bits. The result is then cut back to 16 bits by dropping 14 fraction bits, without rounding, and clamped at the limits of the 16-bit range.

Top module: `twd_mult`

## Requirements
- R1: `out_valid` equals `in_valid` from exactly two rising clock edges earlier, and the result of a sample appears in the same cycle as its `out_valid`.
- R2: With `inverse`=0 and exponent e, the output equals floor((x * (K(r') - j*K(16-r'))) / 2^14) after an exact pre-rotation of x by (-j)^q. Here q = e[5:4], r' = e[3:0], and K(m) = round(16384*cos(m*pi/32)). Real and imaginary parts use signed two's complement.
- R3: With `inverse`=1, the factor is the conjugate. The pre-rotation is by (+j)^q and the residue factor is K(r') + j*K(16-r'), with the same truncation as R2.
- R4: Exponent 0 passes both parts through unchanged in either mode, including the value -32768.
- R5: Exponents 16, 32 and 48 rotate by exact quarter turns: a swap of the parts and/or negation with no loss of precision, apart from clamping per R6.
- R6: A part whose truncated value exceeds 32767 is output as 32767, and one below -32768 is output as -32768.
- R7: While no valid sample is present, `out_re` and `out_im` keep their last values, whatever the other inputs do.
- R8: Synchronous active-high reset `rst` clears `out_valid`, `out_re` and `out_im` to 0.
- R9: Every exponent value 0 to 63 is accepted, and back-to-back samples with different exponents and modes each produce their own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A sample is present this cycle |
| in_re | input | 16 | Real part of the sample, signed |
| in_im | input | 16 | Imaginary part of the sample, signed |
| exp_sel | input | 6 | Twiddle exponent e, 0 to 63 |
| inverse | input | 1 | 0 selects the forward factor, 1 selects the conjugate factor |
| out_valid | output | 1 | Result valid, two cycles after `in_valid` |
| out_re | output | 16 | Real part of the result, signed |
| out_im | output | 16 | Imaginary part of the result, signed |

## Verification
The hardest case to reach is clamping. Normally the factor has unit magnitude, so an output can only leave the 16-bit range when both input parts sit near full scale and the angle is close to 45 degrees. The other route is an exact quarter turn that negates -32768. The stimulus reaches both routes directly: a full-scale sample at exponent 8, and a -32768 part at exponent 16 in each direction. These vectors run inside a back-to-back stream, so the two-cycle alignment is exercised while the clamp is active.

// File: rtl/twd_pkg.sv
package twd_pkg;

    localparam int DATA_W = 16;
    localparam int EXP_W  = 6;
    localparam int FRAC_W = 14;
    localparam int ROT_W  = DATA_W + 1;
    localparam int ACC_W  = 2 * DATA_W;
    localparam int RES_W  = EXP_W - 2;
    localparam int NCOEF  = (1 << RES_W) + 1;
    localparam int CSD_W  = FRAC_W + 2;
    localparam int IDX_W  = RES_W + 1;

    typedef logic signed [DATA_W-1:0] word_t;
    typedef logic signed [ROT_W-1:0]  rword_t;
    typedef logic signed [ACC_W-1:0]  acc_t;

    typedef enum logic [1:0] {
        QT_NONE = 2'd0,
        QT_NEGJ = 2'd1,
        QT_NEG  = 2'd2,
        QT_POSJ = 2'd3
    } quarter_t;

    typedef struct packed {
        logic             vld;
        logic             inv;
        logic             byp;
        logic [RES_W-1:0] res;
        rword_t           a;
        rword_t           b;
    } stage1_t;

    typedef struct packed {
        logic  vld;
        word_t re;
        word_t im;
    } stage2_t;

    function automatic int coef_q14(input int m);
        case (m)
            0:  return 16384;
            1:  return 16305;
            2:  return 16069;
            3:  return 15679;
            4:  return 15137;
            5:  return 14449;
            6:  return 13623;
            7:  return 12665;
            8:  return 11585;
            9:  return 10394;
            10: return 9102;
            11: return 7723;
            12: return 6270;
            13: return 4756;
            14: return 3196;
            15: return 1606;
            default: return 0;
        endcase
    endfunction

    function automatic logic [CSD_W-1:0] csd_digits(input int value, input bit want_pos);
        int v;
        logic [CSD_W-1:0] d;
        v = value;
        d = '0;
        for (int i = 0; i < CSD_W; i++) begin
            if ((v % 2) != 0) begin
                if ((v % 4) == 1) begin
                    d[i] = want_pos;
                    v = v - 1;
                end else begin
                    d[i] = !want_pos;
                    v = v + 1;
                end
            end
            v = v / 2;
        end
        return d;
    endfunction

    function automatic word_t trunc_sat(input acc_t acc);
        acc_t sh;
        sh = acc >>> FRAC_W;
        if (sh > acc_t'((1 << (DATA_W - 1)) - 1))
            return word_t'((1 << (DATA_W - 1)) - 1);
        else if (sh < -acc_t'(1 << (DATA_W - 1)))
            return word_t'(1 << (DATA_W - 1));
        else
            return sh[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/twd_quad_rot.sv
module twd_quad_rot
    import twd_pkg::*;
(
    input  word_t    x_re,
    input  word_t    x_im,
    input  quarter_t turn,
    output rword_t   y_a,
    output rword_t   y_b
);
    rword_t er;
    rword_t ei;

    assign er = rword_t'(x_re);
    assign ei = rword_t'(x_im);

    always_comb begin
        case (turn)
            QT_NONE: begin y_a = er;  y_b = ei;  end
            QT_NEGJ: begin y_a = ei;  y_b = -er; end
            QT_NEG:  begin y_a = -er; y_b = -ei; end
            default: begin y_a = -ei; y_b = er;  end
        endcase
    end
endmodule

// File: rtl/twd_csd_mult.sv
module twd_csd_mult
    import twd_pkg::*;
#(
    parameter int COEF = 16384
)(
    input  rword_t x,
    output acc_t   p
);
    localparam logic [CSD_W-1:0] POS = csd_digits(COEF, 1'b1);
    localparam logic [CSD_W-1:0] NEG = csd_digits(COEF, 1'b0);

    acc_t xe;
    acc_t term [CSD_W];

    assign xe = acc_t'(x);

    for (genvar i = 0; i < CSD_W; i++) begin : g_term
        if (POS[i]) begin : g_add
            assign term[i] = xe <<< i;
        end else if (NEG[i]) begin : g_sub
            assign term[i] = -(xe <<< i);
        end else begin : g_nil
            assign term[i] = '0;
        end
    end

    always_comb begin
        p = '0;
        for (int i = 0; i < CSD_W; i++) p = p + term[i];
    end
endmodule

// File: rtl/twd_coef_bank.sv
module twd_coef_bank
    import twd_pkg::*;
(
    input  rword_t x,
    output acc_t   prod [NCOEF]
);
    for (genvar m = 0; m < NCOEF; m++) begin : g_coef
        twd_csd_mult #(.COEF(coef_q14(m))) u_mult (
            .x (x),
            .p (prod[m])
        );
    end
endmodule

// File: rtl/twd_mult.sv
module twd_mult
    import twd_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  in_valid,
    input  logic [DATA_W-1:0]     in_re,
    input  logic [DATA_W-1:0]     in_im,
    input  logic [EXP_W-1:0]      exp_sel,
    input  logic                  inverse,
    output logic                  out_valid,
    output logic [DATA_W-1:0]     out_re,
    output logic [DATA_W-1:0]     out_im
);
    // stage 1: quarter-turn pre-rotation
    quarter_t fwd_turn;
    quarter_t eff_turn;
    rword_t   rot_a;
    rword_t   rot_b;
    stage1_t  s1;

    assign fwd_turn = quarter_t'(exp_sel[EXP_W-1:EXP_W-2]);
    assign eff_turn = inverse ? quarter_t'(2'd0 - fwd_turn) : fwd_turn;

    twd_quad_rot u_rot (
        .x_re (word_t'(in_re)),
        .x_im (word_t'(in_im)),
        .turn (eff_turn),
        .y_a  (rot_a),
        .y_b  (rot_b)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.vld <= in_valid;
            if (in_valid) begin
                s1.inv <= inverse;
                s1.byp <= (exp_sel == '0);
                s1.res <= exp_sel[RES_W-1:0];
                s1.a   <= rot_a;
                s1.b   <= rot_b;
            end
        end
    end

    // stage 2: residue angle by constant networks, truncate, clamp
    acc_t pa [NCOEF];
    acc_t pb [NCOEF];

    twd_coef_bank u_bank_a (.x(s1.a), .prod(pa));
    twd_coef_bank u_bank_b (.x(s1.b), .prod(pb));

    logic [IDX_W-1:0] cidx;
    logic [IDX_W-1:0] sidx;
    acc_t    acc_re;
    acc_t    acc_im;
    stage2_t s2_next;
    stage2_t s2;

    assign cidx = {1'b0, s1.res};
    assign sidx = IDX_W'(NCOEF - 1) - cidx;

    always_comb begin
        if (s1.inv) begin
            acc_re = pa[cidx] - pb[sidx];
            acc_im = pb[cidx] + pa[sidx];
        end else begin
            acc_re = pa[cidx] + pb[sidx];
            acc_im = pb[cidx] - pa[sidx];
        end
        s2_next.vld = s1.vld;
        if (s1.byp) begin
            s2_next.re = s1.a[DATA_W-1:0];
            s2_next.im = s1.b[DATA_W-1:0];
        end else begin
            s2_next.re = trunc_sat(acc_re);
            s2_next.im = trunc_sat(acc_im);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2 <= '0;
        end else begin
            s2.vld <= s2_next.vld;
            if (s1.vld) begin
                s2.re <= s2_next.re;
                s2.im <= s2_next.im;
            end
        end
    end

    assign out_valid = s2.vld;
    assign out_re    = s2.re;
    assign out_im    = s2.im;

    // cycles since reset, saturating at 2, for history-based checks
    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    a_r1_valid_latency: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    a_r4_bypass: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2 && $past(in_valid, 2) && $past(exp_sel, 2) == '0)
        |-> (out_re == $past(in_re, 2) && out_im == $past(in_im, 2)));

    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        !s1.vld |=> ($stable(out_re) && $stable(out_im)));

    a_r8_reset_clear: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_re == '0 && out_im == '0));

    a_r5_quarter_zero: assert property (@(posedge clk) disable iff (rst)
        (since_rst == 2'd2 && $past(in_valid, 2) && $past(exp_sel, 2) == 6'd32
         && $past(in_re, 2) == '0 && $past(in_im, 2) == '0)
        |-> (out_re == '0 && out_im == '0));
endmodule

// File: tb/twd_mult_bench.sv
module twd_mult_bench;
    localparam int N = 12;
    localparam real PI = 3.14159265358979;

    // vector table: direction, exponent, real, imaginary
    localparam int V_INV [N] = '{0, 0, 0, 0, 1, 1, 0, 1, 0, 1, 0, 1};
    localparam int V_E   [N] = '{1, 7, 9, 35, 1, 21, 49, 8, 63, 40, 8, 16};
    localparam int V_RE  [N] = '{1000, 32767, -12345, 30000, 1000, -32768,
                                 12000, 23170, -1, 32767, 32767, 5};
    localparam int V_IM  [N] = '{-2000, 32767, 22222, -30000, -2000, 32767,
                                 5000, -23170, -1, -32768, 32767, -32768};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic [15:0] in_re = '0;
    logic [15:0] in_im = '0;
    logic [5:0]  exp_sel = '0;
    logic        inverse = 1'b0;
    logic        out_valid;
    logic [15:0] out_re;
    logic [15:0] out_im;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    twd_mult u_twd_mult (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_re     (in_re),
        .in_im     (in_im),
        .exp_sel   (exp_sel),
        .inverse   (inverse),
        .out_valid (out_valid),
        .out_re    (out_re),
        .out_im    (out_im)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: actual=%0d expected<20000 cycles", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int kq(input int m);
        return $rtoi($floor(16384.0 * $cos(m * PI / 32.0) + 0.5));
    endfunction

    function automatic int clamp(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    // expected result from the requirements (R2, R3, R4, R5, R6)
    task automatic model(input int inv, input int e, input int xr, input int xi,
                         output int er, output int ei);
        int q, r, k;
        longint a, b, c, s, pr, pi_;
        if (e == 0) begin
            er = xr; ei = xi;
            return;
        end
        q = e / 16;
        r = e % 16;
        k = inv ? ((4 - q) % 4) : q;
        case (k)
            0: begin a = xr;  b = xi;  end
            1: begin a = xi;  b = -xr; end
            2: begin a = -xr; b = -xi; end
            default: begin a = -xi; b = xr; end
        endcase
        c = kq(r);
        s = kq(16 - r);
        if (inv) begin
            pr = a * c - b * s;
            pi_ = b * c + a * s;
        end else begin
            pr = a * c + b * s;
            pi_ = b * c - a * s;
        end
        er = clamp(pr >>> 14);
        ei = clamp(pi_ >>> 14);
    endtask

    task automatic drive(input int inv, input int e, input int xr, input int xi);
        in_valid = 1'b1;
        inverse  = inv[0];
        exp_sel  = e[5:0];
        in_re    = xr[15:0];
        in_im    = xi[15:0];
    endtask

    task automatic single(input string tag, input int inv, input int e,
                          input int xr, input int xi);
        int er, ei;
        model(inv, e, xr, xi, er, ei);
        @(negedge clk);
        drive(inv, e, xr, xi);
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk({tag, " valid"}, int'(out_valid), 1);
        chk({tag, " re"}, int'($signed(out_re)), er);
        chk({tag, " im"}, int'($signed(out_im)), ei);
    endtask

    initial begin
        int er, ei, hold_re, hold_im;
        // R8: reset state
        repeat (3) @(negedge clk);
        chk("R8 reset valid", int'(out_valid), 0);
        chk("R8 reset re", int'($signed(out_re)), 0);
        chk("R8 reset im", int'($signed(out_im)), 0);
        rst = 1'b0;

        // R1, R2, R3, R6, R9: table streamed back to back
        for (int k = 0; k < N + 2; k++) begin
            @(negedge clk);
            if (k >= 2) begin
                model(V_INV[k-2], V_E[k-2], V_RE[k-2], V_IM[k-2], er, ei);
                chk($sformatf("R1 stream valid %0d", k - 2), int'(out_valid), 1);
                chk($sformatf("R2/R3/R9 stream re %0d", k - 2), int'($signed(out_re)), er);
                chk($sformatf("R2/R3/R9 stream im %0d", k - 2), int'($signed(out_im)), ei);
            end
            if (k < N) drive(V_INV[k], V_E[k], V_RE[k], V_IM[k]);
            else in_valid = 1'b0;
        end
        @(negedge clk);
        chk("R1 valid drops", int'(out_valid), 0);

        // R6: clamp at +45 degrees and on an exact quarter turn of -32768
        single("R6 sat45", 0, 8, 32767, 32767);
        chk("R6 sat45 value", int'($signed(out_re)), 32767);
        single("R6 negj", 0, 16, -32768, 0);
        chk("R6 negj value", int'($signed(out_im)), 32767);
        single("R6 posj inverse", 1, 16, 0, -32768);
        chk("R6 posj value", int'($signed(out_re)), 32767);

        // R4: exponent 0 bypass in both modes
        single("R4 bypass fwd", 0, 0, -32768, 32767);
        chk("R4 bypass fwd exact", int'($signed(out_re)), -32768);
        single("R4 bypass inv", 1, 0, 12345, -32768);
        chk("R4 bypass inv exact", int'($signed(out_im)), -32768);

        // R5: exact quarter turns
        single("R5 e32", 0, 32, 1234, -4321);
        chk("R5 e32 re", int'($signed(out_re)), -1234);
        single("R5 e48 fwd", 0, 48, 777, 333);
        chk("R5 e48 re", int'($signed(out_re)), -333);
        chk("R5 e48 im", int'($signed(out_im)), 777);
        single("R5 e16 inv", 1, 16, 777, 333);
        chk("R5 e16 inv re", int'($signed(out_re)), -333);

        // R3: conjugate mode against forward on the same sample
        single("R3 inv e5", 1, 5, 20000, 3000);
        single("R2 fwd e5", 0, 5, 20000, 3000);

        // R7: outputs hold while no valid sample arrives
        hold_re = int'($signed(out_re));
        hold_im = int'($signed(out_im));
        @(negedge clk);
        in_re = 16'h1111; in_im = 16'h2222; exp_sel = 6'd13; inverse = 1'b1;
        repeat (4) @(negedge clk);
        chk("R7 hold valid", int'(out_valid), 0);
        chk("R7 hold re", int'($signed(out_re)), hold_re);
        chk("R7 hold im", int'($signed(out_im)), hold_im);

        // R8: reset after activity
        single("R2 before reset", 0, 3, 15000, -15000);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R8 rerst valid", int'(out_valid), 0);
        chk("R8 rerst re", int'($signed(out_re)), 0);
        chk("R8 rerst im", int'($signed(out_im)), 0);
        rst = 1'b0;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule